// File: doc/BRIEF.md
# Two-Wire Slave with Write-Gated Register Window

This block is a two-wire serial slave that opens an 80-byte window onto a small register file and a lookup table. The window starts at byte address 80h. The sixteen bytes from 80h to 8Fh are control bytes. The sixty-four bytes from 90h to CFh form a lookup table, and its contents are also readable in parallel through a dedicated index port.

Each bus transfer opens with a START and a 7-bit device address. The upper four bits of that address are a fixed device type, and the lower three bits are set by pins. One register-address byte follows, then data bytes. All data moves MSB first. A write-enable bit at bit 7 of address 80h guards every other bit of the window. Bytes the map marks as reserved ignore writes and read back as zero.

The bus lines arrive as oversampled levels on the system clock. The block drives the data line only through an open-drain pull-down enable.

Top module: `twi_lut_slave`

## Requirements
- R1: After reset, every lookup-table byte and the byte at 80h read 00h, and the pull-down enable is low.
- R2: The slave acknowledges only a device address whose bits 7..4 are 1010b and whose bits 3..1 equal dev_pins; bit 0 is 1 for read and 0 for write. On any other device address it leaves SDA released until the next START.
- R3: A register-address byte from 80h to CFh is acknowledged. Any other value is not acknowledged, and the slave then goes idle.
- R4: Bytes are received MSB first, and every written data byte is acknowledged.
- R5: Bit 7 of 80h (the write-enable bit) takes the written value on every write to 80h. Bits 6..0 of 80h, and every other byte, change only when the write-enable bit was already 1 before that byte arrived.
- R6: Writes to 82h, 84h and 88h–8Fh change nothing, and those addresses read 00h.
- R7: After each data byte, the address pointer advances within its 16-byte page, so that 9Fh is followed by 90h.
- R8: A read sends bytes MSB first and continues while the master acknowledges. After a master not-acknowledge, the slave releases SDA.
- R9: A read with no address byte returns data from the pointer that the last address byte set. This holds across a repeated START or a STOP.
- R10: A STOP at any bit position returns the slave to idle with SDA released.
- R11: lut_rd_data shows the lookup-table byte at index lut_rd_idx (address 90h plus the index) one clock after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired bus value) |
| dev_pins | input | 3 | Low three bits of the device address |
| lut_rd_idx | input | 6 | Lookup-table index for the parallel read port |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| lut_rd_data | output | 8 | Registered lookup-table byte at lut_rd_idx |

## Verification
Two things can happen on the same clock edge. A byte written to 80h updates the write-enable bit, and the same byte is also gated by that bit. The gate must use the value of the bit from before the byte. The bench provokes this with a sequence of writes to 80h: 80h, FFh, 05h, 7Ah, then 80h again. It expects readbacks of 80h, FFh, 05h, 05h and 85h. This shows that a byte which clears the bit still lands, and that a byte which would set bits while the bit is clear has no effect on them. Random write runs that cross 80h then reorder the bit against the writes that follow it, and every byte is compared with a bench model.

// File: rtl/twi_lut_pkg.sv
package twi_lut_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_state_e;
  typedef enum logic [1:0] {PH_DEV, PH_REG, PH_DATA} byte_phase_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sr, sda_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_raw};
      sda_sr <= {sda_sr[STAGES-1:0], sda_raw};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now   = scl_sr[STAGES-1];
  assign scl_old   = scl_sr[STAGES];
  assign sda_now   = sda_sr[STAGES-1];
  assign sda_old   = sda_sr[STAGES];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int                   CTL_BYTES = 16,
  parameter int                   LUT_BYTES = 64,
  parameter logic [7:0]           BASE_ADDR = 8'h80,
  parameter logic [CTL_BYTES-1:0] RSV_MASK  = 16'hFF14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic [7:0]                   rd_addr,
  output logic [7:0]                   rd_data,
  input  logic [$clog2(LUT_BYTES)-1:0] lut_idx,
  output logic [7:0]                   lut_q
);
  localparam int         LUT_AW   = $clog2(LUT_BYTES);
  localparam int         CTL_AW   = $clog2(CTL_BYTES);
  localparam logic [7:0] LUT_BASE = BASE_ADDR + 8'(CTL_BYTES);

  logic [CTL_BYTES-1:0][7:0] ctl_w;
  logic                      wel;

  for (genvar i = 0; i < CTL_BYTES; i++) begin : g_ctl
    localparam logic [7:0] ADDR_I = BASE_ADDR + 8'(i);
    if (RSV_MASK[i]) begin : g_rsv
      assign ctl_w[i] = 8'h00;
    end else begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr_en && wr_addr == ADDR_I) begin
          if (i == 0) q <= {wr_data[7], wel ? wr_data[6:0] : q[6:0]};
          else if (wel) q <= wr_data;
        end
      end
      assign ctl_w[i] = q;
    end
  end

  assign wel = ctl_w[0][7];

  // Lookup table: reset-free storage plus a valid vector that reads 00h until written
  logic [7:0]           lut_mem [LUT_BYTES];
  logic [LUT_BYTES-1:0] lut_vld;
  logic [LUT_AW-1:0]    lut_wi, lut_ri;
  logic [CTL_AW-1:0]    ctl_ri, ctl_wi;
  logic                 lut_wr;

  assign lut_wi = LUT_AW'(wr_addr - LUT_BASE);
  assign lut_ri = LUT_AW'(rd_addr - LUT_BASE);
  assign ctl_ri = CTL_AW'(rd_addr - BASE_ADDR);
  assign ctl_wi = CTL_AW'(wr_addr - BASE_ADDR);
  assign lut_wr = wr_en && wel && (wr_addr >= LUT_BASE);

  always_ff @(posedge clk) begin
    if (lut_wr) lut_mem[lut_wi] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) lut_vld <= '0;
    else if (lut_wr) lut_vld[lut_wi] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lut_q <= '0;
    else     lut_q <= lut_vld[lut_idx] ? lut_mem[lut_idx] : 8'h00;
  end

  always_comb begin
    if (rd_addr >= LUT_BASE) rd_data = lut_vld[lut_ri] ? lut_mem[lut_ri] : 8'h00;
    else                     rd_data = ctl_w[ctl_ri];
  end

  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wel && wr_addr != BASE_ADDR) |=> ($stable(ctl_w) && $stable(lut_vld)));
  // R5
  wel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == BASE_ADDR) |=> (wel == $past(wr_data[7])));
  // R6
  rsv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < LUT_BASE && RSV_MASK[ctl_wi]) |=> ($stable(ctl_w) && $stable(lut_vld)));
endmodule

// File: rtl/twi_lut_slave.sv
module twi_lut_slave
  import twi_lut_pkg::*;
#(
  parameter int                   CTL_BYTES   = 16,
  parameter int                   LUT_BYTES   = 64,
  parameter int                   PAGE_BYTES  = 16,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [7:0]           BASE_ADDR   = 8'h80,
  parameter logic [3:0]           DEV_TYPE    = 4'b1010,
  parameter logic [CTL_BYTES-1:0] RSV_MASK    = 16'hFF14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_in,
  input  logic                         sda_in,
  input  logic [2:0]                   dev_pins,
  input  logic [$clog2(LUT_BYTES)-1:0] lut_rd_idx,
  output logic                         sda_pull,
  output logic [7:0]                   lut_rd_data
);
  localparam int         PG_W      = $clog2(PAGE_BYTES);
  localparam logic [7:0] LAST_ADDR = BASE_ADDR + 8'(CTL_BYTES + LUT_BYTES - 1);

  function automatic logic [7:0] page_next(input logic [7:0] a);
    logic [7:0] n;
    n = a;
    n[PG_W-1:0] = a[PG_W-1:0] + PG_W'(1);
    return n;
  endfunction

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_state_e  st_q;
  byte_phase_e ph_q;
  logic [3:0]  cnt_q;
  logic [7:0]  rx_q, tx_q, ptr_q, wr_addr_q, wr_data_q, rd_data;
  logic        rw_q, mack_q, wr_en_q;

  twi_regfile #(
    .CTL_BYTES(CTL_BYTES), .LUT_BYTES(LUT_BYTES),
    .BASE_ADDR(BASE_ADDR), .RSV_MASK(RSV_MASK)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_q), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
    .rd_addr(ptr_q), .rd_data(rd_data),
    .lut_idx(lut_rd_idx), .lut_q(lut_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_DEV;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= BASE_ADDR;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      sda_pull  <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        st_q     <= ST_RX;
        ph_q     <= PH_DEV;
        cnt_q    <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[6:0], sda_lvl};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              unique case (ph_q)
                PH_DEV: begin
                  if (rx_q[7:1] == {DEV_TYPE, dev_pins}) begin
                    rw_q     <= rx_q[0];
                    sda_pull <= 1'b1;
                    st_q     <= ST_ACK;
                  end else st_q <= ST_IDLE;
                end
                PH_REG: begin
                  if (rx_q >= BASE_ADDR && rx_q <= LAST_ADDR) begin
                    ptr_q    <= rx_q;
                    sda_pull <= 1'b1;
                    st_q     <= ST_ACK;
                  end else st_q <= ST_IDLE;
                end
                default: begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= rx_q;
                  ptr_q     <= page_next(ptr_q);
                  sda_pull  <= 1'b1;
                  st_q      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph_q == PH_DEV && rw_q) begin
                sda_pull <= ~rd_data[7];
                tx_q     <= {rd_data[6:0], 1'b0};
                ptr_q    <= page_next(ptr_q);
                cnt_q    <= 4'd1;
                st_q     <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                cnt_q    <= '0;
                ph_q     <= (ph_q == PH_DEV) ? PH_REG : PH_DATA;
                st_q     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_pull <= 1'b0;
                st_q     <= ST_MACK;
              end else begin
                sda_pull <= ~tx_q[7];
                tx_q     <= {tx_q[6:0], 1'b0};
                cnt_q    <= cnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_q <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack_q) begin
                sda_pull <= ~rd_data[7];
                tx_q     <= {rd_data[6:0], 1'b0};
                ptr_q    <= page_next(ptr_q);
                cnt_q    <= 4'd1;
                st_q     <= ST_TX;
              end else st_q <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st_q == ST_IDLE && !sda_pull));
  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st_q == ST_RX && ph_q == PH_DEV && !sda_pull));
  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_q == ST_RX && ph_q == PH_REG) |=> (ptr_q[7:PG_W] == $past(ptr_q[7:PG_W])));
  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_q >= BASE_ADDR && ptr_q <= LAST_ADDR));
  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RX || st_q == ST_MACK) |-> !sda_pull);
endmodule

// File: tb/test_twi_lut_slave.sv
module test_twi_lut_slave;
  localparam int Q = 6;
  localparam logic [7:0] DW = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] DR = {4'b1010, 3'b101, 1'b1};

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [5:0] lidx = '0;
  logic sda_pull, sda_bus;
  logic [7:0] lq;
  assign sda_bus = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  twi_lut_slave i_twi_lut_slave (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .dev_pins(pins),
    .lut_rd_idx(lidx), .sda_pull(sda_pull), .lut_rd_data(lq)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [80];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  function automatic bit is_rsv(input logic [7:0] a);
    return a == 8'h82 || a == 8'h84 || (a >= 8'h88 && a <= 8'h8F);
  endfunction

  task automatic mdl_wr(input logic [7:0] a, input logic [7:0] d);
    logic w;
    w = mdl[0][7];
    if (a == 8'h80) mdl[0] = {d[7], w ? d[6:0] : mdl[0][6:0]};
    else if (!is_rsv(a) && w) mdl[a - 8'h80] = d;
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = (sda_bus == 1'b0); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0;
    end
    wq();
    sda_m = mack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_txn(input logic [7:0] a, input int n, output bit ok);
    bit k;
    logic [7:0] cur;
    b_start();
    send_byte(DW, k); ok = k;
    send_byte(a, k); ok &= k;
    cur = a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k); ok &= k;
      mdl_wr(cur, wbuf[i]);
      cur = nxt(cur);
    end
    b_stop();
  endtask

  task automatic rd_txn(input logic [7:0] a, input int n, output bit ok);
    bit k;
    b_start();
    send_byte(DW, k); ok = k;
    send_byte(a, k); ok &= k;
    b_start();
    send_byte(DR, k); ok &= k;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
    b_stop();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, input string tag);
    bit ok;
    wbuf[0] = d;
    wr_txn(a, 1, ok);
    chk(ok, tag, ok, 1);
  endtask

  task automatic rd_expect(input logic [7:0] a, input int n, input string tag);
    bit ok;
    logic [7:0] cur;
    rd_txn(a, n, ok);
    chk(ok, tag, ok, 1);
    cur = a;
    for (int i = 0; i < n; i++) begin
      chk(rbuf[i] == mdl[cur - 8'h80], tag, rbuf[i], mdl[cur - 8'h80]);
      cur = nxt(cur);
    end
  endtask

  task automatic lut_port(input int idx, input string tag);
    lidx = 6'(idx);
    @(negedge clk); @(negedge clk);
    chk(lq == mdl[16 + idx], tag, lq, mdl[16 + idx]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ok, k;
    logic [7:0] b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 80; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    for (int i = 0; i < 64; i++) lut_port(i, "R1 R11 lut reset");
    rd_expect(8'h80, 1, "R1 ctl80 reset");

    // R5: gated write while enable clear
    wr1(8'h90, 8'hFF, "R4 ack with enable clear");
    rd_expect(8'h90, 1, "R5 blocked lut write");
    chk(mdl[16] == 8'h00, "R5 model", mdl[16], 0);

    // R5: enable set; R4 asymmetric bytes
    wr1(8'h80, 8'h80, "R5 set enable");
    chk(mdl[0] == 8'h80, "R5 model", mdl[0], 8'h80);
    rd_expect(8'h80, 1, "R5 enable readback");
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    wr_txn(8'h90, 2, ok);
    chk(ok, "R4 data acks", ok, 1);
    rd_expect(8'h90, 2, "R4 msb first");

    // R5: same-edge update and gating of 80h
    wr1(8'h80, 8'hFF, "R5 ack");
    rd_expect(8'h80, 1, "R5 80h FF");
    wr1(8'h80, 8'h05, "R5 ack");
    chk(mdl[0] == 8'h05, "R5 model", mdl[0], 8'h05);
    rd_expect(8'h80, 1, "R5 clear lands");
    wr1(8'h80, 8'h7A, "R5 ack");
    chk(mdl[0] == 8'h05, "R5 model", mdl[0], 8'h05);
    rd_expect(8'h80, 1, "R5 bits held");
    wr1(8'h80, 8'h80, "R5 ack");
    rd_expect(8'h80, 1, "R5 80h 85");

    // R6: reserved bytes
    wbuf[0] = 8'h11; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    wr_txn(8'h81, 3, ok);
    chk(ok, "R6 acks", ok, 1);
    wr1(8'h8A, 8'hAA, "R6 ack");
    rd_expect(8'h81, 4, "R6 reserved zero");
    rd_expect(8'h8A, 1, "R6 reserved 8A");

    // R7: page wrap, R11 port
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    wr_txn(8'h9E, 3, ok);
    chk(ok, "R7 acks", ok, 1);
    chk(mdl[16] == 8'hA3, "R7 model wrap", mdl[16], 8'hA3);
    rd_expect(8'h9E, 3, "R7 R8 wrap read");
    rd_expect(8'h90, 1, "R7 wrapped byte");
    lut_port(14, "R11 idx14");
    lut_port(15, "R11 idx15");
    lut_port(0, "R11 idx0");

    // R8: release after master NACK
    b_start(); send_byte(DW, k); send_byte(8'h9E, k); b_start(); send_byte(DR, k);
    recv_byte(b, 1'b1);
    chk(b == 8'hA1, "R8 first", b, 8'hA1);
    recv_byte(b, 1'b0);
    chk(b == 8'hA2, "R8 second", b, 8'hA2);
    for (int i = 0; i < 4; i++) begin
      scl_m = 1'b1; wq(); chk(sda_pull == 1'b0, "R8 released", sda_pull, 0); scl_m = 1'b0; wq();
    end
    b_stop();

    // R2: wrong device address
    b_start();
    send_byte({4'b1010, 3'b011, 1'b0}, k);
    chk(!k, "R2 wrong pins nack", k, 0);
    send_byte(8'h90, k);
    chk(!k, "R2 stays silent", k, 0);
    b_stop();
    b_start();
    send_byte({4'b1011, 3'b101, 1'b0}, k);
    chk(!k, "R2 wrong type nack", k, 0);
    b_stop();

    // R3: register address range
    b_start(); send_byte(DW, k); send_byte(8'h7F, k); chk(!k, "R3 7F nack", k, 0); b_stop();
    b_start(); send_byte(DW, k); send_byte(8'hD0, k); chk(!k, "R3 D0 nack", k, 0); b_stop();
    b_start(); send_byte(DW, k); send_byte(8'hCF, k); chk(k, "R3 CF ack", k, 1); b_stop();

    // R10: stop mid-byte
    b_start(); send_byte(DW, k);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    b_stop();
    chk(sda_pull == 1'b0, "R10 released", sda_pull, 0);
    wr1(8'hA0, 8'h5A, "R10 after stop");

    // R9: pointer kept across STOP
    b_start(); send_byte(DW, k); send_byte(8'hA0, k); b_stop();
    b_start(); send_byte(DR, k); chk(k, "R9 ack", k, 1);
    recv_byte(b, 1'b0); b_stop();
    chk(b == 8'h5A, "R9 pointer read", b, 8'h5A);

    // random mix, R4 R5 R7 R8
    for (int it = 0; it < 16; it++) begin
      logic [7:0] a;
      int n;
      if ($urandom % 2 == 0) wr1(8'h80, 8'h80, "R5 rand enable");
      a = 8'h80 + 8'($urandom % 80);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_txn(a, n, ok);
      chk(ok, "R4 rand acks", ok, 1);
      rd_expect(a, n, "R5 R7 rand readback");
    end

    for (int i = 0; i < 64; i++) lut_port(i, "R11 final scan");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule